// File: doc/BRIEF.md
# Serial Multi-Channel Wiper Code Register

This block is the digital control core of a serially programmed multi-channel potentiometer. A host clocks an 11-bit word into a shift register over a three-wire link: a serial clock, an active-low select and a data line. The word carries a 3-bit channel address, sent first, and an 8-bit wiper code, sent second. Both fields go most significant bit first. When the select line returns high, the address is decoded and the chosen channel's 8-bit wiper latch takes the code. Each channel's code is driven out in parallel to the analog ladder, which lies outside this block.

A serial output lets several devices share one data line. It presents the bit that entered the shift register eleven serial clocks earlier. It changes on the falling clock edge, so the next device has half a period of setup before its rising-edge capture. The pad is open-drain and is modelled as a level plus a pull-low enable. An asynchronous active-low preset returns every channel to mid-code. An active-low shutdown releases the serial output and raises a flag for the analog side. The stored codes are kept through shutdown.

The link has no valid/ready handshake and no back-pressure. The select line frames a transfer, and the host owns all timing. The control pins are plain levels.

Top module: `multi_wiper_ctrl`

## Requirements
- R1: While preset is low, every wiper code reads 0x80 and the serial holding stage is cleared. The serial output then reads 0 with its pull-low enable at 1, provided shutdown is high.
- R2: While select is low, each rising serial clock edge shifts the data input into the shift register. The word is 11 bits, most significant bit first: bits 10..8 are the address and bits 7..0 are the wiper code.
- R3: A rising edge on select loads the addressed channel with bits 7..0 of the shift register. All other channels keep their codes.
- R4: Only the last 11 bits shifted before select rises are used. Any earlier bits are discarded.
- R5: Serial clock edges while select is high change neither the shift register nor the serial output.
- R6: Address value k loads channel index k, for k from 0 to NUM_CH-1. Any address at or above NUM_CH loads nothing. NUM_CH is 4 or 6.
- R7: The serial output carries the bit that entered the shift register 11 rising edges earlier. It updates on the falling serial clock edge, and the pull-low enable is 1 exactly when the output level is 0.
- R8: While shutdown is low, the serial output level is 1, the pull-low enable is 0 and the shutdown flag is 1. The wiper codes are kept, and the previous serial output returns when shutdown is released.
- R9: The rising edge of preset leaves all codes at 0x80.
- R10: Two four-channel devices are chained, with the first one's serial output driving the second one's data input. After 22 clocks with a shared select held low, one select rise updates one channel in each device. The first 11 bits sent reach the far device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; the shift register captures on the rising edge, the output stage updates on the falling edge |
| csn | input | 1 | Active-low select; its rising edge commits the word |
| sdi | input | 1 | Serial data input |
| presetn | input | 1 | Asynchronous active-low preset to mid-code |
| shdnn | input | 1 | Active-low shutdown |
| sdo_level | output | 1 | Logic level seen on the open-drain serial output |
| sdo_drive_en | output | 1 | 1 while the output transistor pulls the line low |
| wiper_codes | output | NUM_CH*8 | Channel codes; channel k occupies bits k*8+7..k*8 |
| shdn_active | output | 1 | 1 while shutdown is asserted |

## Verification
Every address from 0 to 7 is swept with all-zero, all-one and mixed codes. This exposes decode errors, writes that spill into the wrong channel, and bit-order mistakes. A word preceded by junk bits shows that only the final 11 bits count. A clock burst sent with select high, followed by a select pulse with no clocks, shows that the burst changed nothing. The serial output is sampled during both clock phases of a long non-periodic pattern. This separates an 11-bit delay from a 10- or 12-bit delay and a falling-edge update from a rising-edge one. A two-device chain then shows that the far device receives the first word and that out-of-range addresses on a four-channel build are ignored.

// File: rtl/wiper_ctrl_pkg.sv
package wiper_ctrl_pkg;
  localparam int ADDR_BITS = 3;
  localparam int CODE_BITS = 8;
  localparam int WORD_BITS = ADDR_BITS + CODE_BITS;

  typedef logic [CODE_BITS-1:0] code_t;
  typedef logic [ADDR_BITS-1:0] addr_t;

  typedef struct packed {
    addr_t addr;
    code_t code;
  } word_t;

  localparam code_t MID_CODE = code_t'(1) << (CODE_BITS - 1);
endpackage

// File: rtl/ser_word_shifter.sv
module ser_word_shifter #(
  parameter int WIDTH = 11
) (
  input  logic             sclk,
  input  logic             csn,
  input  logic             presetn,
  input  logic             sdi,
  output logic [WIDTH-1:0] word_q
);

  always_ff @(posedge sclk or negedge presetn) begin
    if (!presetn) begin
      word_q <= '0;
    end else if (!csn) begin
      word_q <= {word_q[WIDTH-2:0], sdi};
    end
  end

  // R5
  shift_idle_chk: assert property (@(posedge sclk) disable iff (!presetn)
    csn |=> $stable(word_q));

endmodule

// File: rtl/chain_out_stage.sv
module chain_out_stage (
  input  logic sclk,
  input  logic csn,
  input  logic presetn,
  input  logic shdnn,
  input  logic msb,
  output logic sdo_level,
  output logic sdo_drive_en
);

  logic hold_q;

  always_ff @(negedge sclk or negedge presetn) begin
    if (!presetn) begin
      hold_q <= 1'b0;
    end else if (!csn) begin
      hold_q <= msb;
    end
  end

  assign sdo_level    = shdnn ? hold_q : 1'b1;
  assign sdo_drive_en = shdnn & ~hold_q;

  // R5
  hold_idle_chk: assert property (@(negedge sclk) disable iff (!presetn)
    csn |=> $stable(hold_q));

  // R7
  od_consistent_chk: assert property (@(posedge sclk) disable iff (!presetn)
    sdo_drive_en |-> !sdo_level);

  // R8
  shdn_release_chk: assert property (@(posedge sclk) disable iff (!presetn)
    !shdnn |-> (sdo_level && !sdo_drive_en));

endmodule

// File: rtl/addr_decode.sv
module addr_decode #(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CH-1:0] en
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign en[i] = (addr == ADDR_W'(i));
  end

endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
  import wiper_ctrl_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic                        sclk,
  input  logic                        csn,
  input  logic                        presetn,
  input  logic [NUM_CH-1:0]           en,
  input  code_t                       code_in,
  output logic [NUM_CH*CODE_BITS-1:0] codes
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    code_t code_q;

    always_ff @(posedge csn or negedge presetn) begin
      if (!presetn) begin
        code_q <= MID_CODE;
      end else if (en[i]) begin
        code_q <= code_in;
      end
    end

    assign codes[i*CODE_BITS +: CODE_BITS] = code_q;
  end

  // R3
  codes_hold_chk: assert property (@(posedge sclk) disable iff (!presetn)
    (csn && $past(csn)) |-> $stable(codes));

endmodule

// File: rtl/multi_wiper_ctrl.sv
module multi_wiper_ctrl
  import wiper_ctrl_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic                        sclk,
  input  logic                        csn,
  input  logic                        sdi,
  input  logic                        presetn,
  input  logic                        shdnn,
  output logic                        sdo_level,
  output logic                        sdo_drive_en,
  output logic [NUM_CH*CODE_BITS-1:0] wiper_codes,
  output logic                        shdn_active
);

  logic [WORD_BITS-1:0] word_q;
  word_t                word_s;
  logic [NUM_CH-1:0]    ch_en;

  ser_word_shifter #(.WIDTH(WORD_BITS)) u_shift (
    .sclk    (sclk),
    .csn     (csn),
    .presetn (presetn),
    .sdi     (sdi),
    .word_q  (word_q)
  );

  assign word_s = word_t'(word_q);

  chain_out_stage u_out (
    .sclk         (sclk),
    .csn          (csn),
    .presetn      (presetn),
    .shdnn        (shdnn),
    .msb          (word_q[WORD_BITS-1]),
    .sdo_level    (sdo_level),
    .sdo_drive_en (sdo_drive_en)
  );

  addr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_BITS)) u_dec (
    .addr (word_s.addr),
    .en   (ch_en)
  );

  wiper_bank #(.NUM_CH(NUM_CH)) u_bank (
    .sclk    (sclk),
    .csn     (csn),
    .presetn (presetn),
    .en      (ch_en),
    .code_in (word_s.code),
    .codes   (wiper_codes)
  );

  assign shdn_active = ~shdnn;

endmodule

// File: tb/test_multi_wiper_ctrl.sv
module test_multi_wiper_ctrl;

  logic sclk = 1'b0;
  logic csn_m = 1'b1, csn_c = 1'b1;
  logic sdi_m = 1'b0, sdi_c = 1'b0;
  logic presetn = 1'b1, shdnn = 1'b1;

  logic        sdo_m, drv_m, flag_m;
  logic [47:0] w_m;
  logic        sdo_a, drv_a, flag_a, sdo_b, drv_b, flag_b;
  logic [31:0] w_a, w_b;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [0:5];

  multi_wiper_ctrl #(.NUM_CH(6)) i_multi_wiper_ctrl (
    .sclk(sclk), .csn(csn_m), .sdi(sdi_m), .presetn(presetn), .shdnn(shdnn),
    .sdo_level(sdo_m), .sdo_drive_en(drv_m), .wiper_codes(w_m), .shdn_active(flag_m));

  multi_wiper_ctrl #(.NUM_CH(4)) i_chain_a (
    .sclk(sclk), .csn(csn_c), .sdi(sdi_c), .presetn(presetn), .shdnn(shdnn),
    .sdo_level(sdo_a), .sdo_drive_en(drv_a), .wiper_codes(w_a), .shdn_active(flag_a));

  multi_wiper_ctrl #(.NUM_CH(4)) i_chain_b (
    .sclk(sclk), .csn(csn_c), .sdi(sdo_a), .presetn(presetn), .shdnn(shdnn),
    .sdo_level(sdo_b), .sdo_drive_en(drv_b), .wiper_codes(w_b), .shdn_active(flag_b));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_main(input string tag);
    for (int ch = 0; ch < 6; ch++) chk(tag, w_m[ch*8 +: 8], model[ch]);
  endtask

  // 20 ns period: 50 MHz serial clock
  task automatic send_bit(input logic bm, input logic bc);
    sdi_m = bm;
    sdi_c = bc;
    #5 sclk = 1'b1;
    #10 sclk = 1'b0;
    #5;
  endtask

  task automatic shift_main(input logic [10:0] w);
    csn_m = 1'b0;
    #5;
    for (int i = 10; i >= 0; i--) send_bit(w[i], 1'b0);
    csn_m = 1'b1;
    #10;
    if (w[10:8] < 3'd6) model[w[10:8]] = w[7:0];
  endtask

  function automatic logic [7:0] code_for(input int k, input int a);
    case (k)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'(a * 37 + 5);
      default: return 8'h55 ^ 8'(a);
    endcase
  endfunction

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [29:0] pb;
    logic [10:0] w;
    logic [21:0] cw;

    for (int c = 0; c < 6; c++) model[c] = 8'h80;

    // R1: preset low
    #1 presetn = 1'b0;
    #10;
    check_main("R1 preset codes");
    for (int c = 0; c < 4; c++) begin
      chk("R1 chain a codes", w_a[c*8 +: 8], 8'h80);
      chk("R1 chain b codes", w_b[c*8 +: 8], 8'h80);
    end
    chk("R1 sdo level", {7'd0, sdo_m}, 8'd0);
    chk("R1 sdo drive", {7'd0, drv_m}, 8'd1);
    chk("R1 flag", {7'd0, flag_m}, 8'd0);
    // R9: release
    presetn = 1'b1;
    #10;
    check_main("R9 preset rise");

    // R2 R3 R6: address and code sweep
    for (int a = 0; a < 8; a++) begin
      for (int k = 0; k < 4; k++) begin
        shift_main({3'(a), code_for(k, a)});
        check_main(a >= 6 ? "R6 out-of-range addr" : "R3 addressed load");
      end
    end

    // R4: junk bits in front of the word
    csn_m = 1'b0;
    #5;
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
    w = {3'd4, 8'h6B};
    for (int i = 10; i >= 0; i--) send_bit(w[i], 1'b0);
    csn_m = 1'b1;
    #10;
    model[4] = 8'h6B;
    check_main("R4 last 11 bits");

    // R7: serial output delay and edge
    for (int i = 0; i < 30; i++) pb[i] = (((i * 5 + 1) % 3) == 0) || (i % 7 == 2);
    csn_m = 1'b0;
    #5;
    for (int i = 0; i < 30; i++) begin
      sdi_m = pb[i];
      #5 sclk = 1'b1;
      #5;
      if (i >= 11) chk("R7 sdo high phase", {7'd0, sdo_m}, {7'd0, pb[i-11]});
      #5 sclk = 1'b0;
      #5;
      if (i >= 10) begin
        chk("R7 sdo low phase", {7'd0, sdo_m}, {7'd0, pb[i-10]});
        chk("R7 drive polarity", {7'd0, drv_m}, {7'd0, ~pb[i-10]});
      end
    end
    csn_m = 1'b1;
    #10;
    for (int j = 0; j < 11; j++) w[10-j] = pb[19+j];
    if (w[10:8] < 3'd6) model[w[10:8]] = w[7:0];
    check_main("R7 chained word load");

    // R5: clocks with select high
    shift_main({3'd0, 8'h11});
    shift_main({3'd2, 8'h33});
    w = {3'd0, 8'hEE};
    for (int i = 10; i >= 0; i--) send_bit(w[i], 1'b0);
    chk("R5 sdo idle", {7'd0, sdo_m}, 8'd0);
    csn_m = 1'b0;
    #5 csn_m = 1'b1;
    #10;
    check_main("R5 no shift when deselected");

    // R8: shutdown
    shdnn = 1'b0;
    #5;
    chk("R8 sdo released", {7'd0, sdo_m}, 8'd1);
    chk("R8 drive off", {7'd0, drv_m}, 8'd0);
    chk("R8 flag", {7'd0, flag_m}, 8'd1);
    for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0);
    check_main("R8 codes kept");
    shdnn = 1'b1;
    #5;
    chk("R8 sdo restored", {7'd0, sdo_m}, 8'd0);
    chk("R8 flag cleared", {7'd0, flag_m}, 8'd0);
    check_main("R8 codes after release");

    // R10: two chained four-channel devices
    cw = {3'd1, 8'hA5, 3'd3, 8'h5A};
    csn_c = 1'b0;
    #5;
    for (int i = 21; i >= 0; i--) send_bit(1'b0, cw[i]);
    csn_c = 1'b1;
    #10;
    for (int c = 0; c < 4; c++) begin
      chk("R10 near device", w_a[c*8 +: 8], (c == 3) ? 8'h5A : 8'h80);
      chk("R10 far device", w_b[c*8 +: 8], (c == 1) ? 8'hA5 : 8'h80);
    end
    // R6: addresses 4 and 5 on four-channel builds
    cw = {3'd4, 8'h77, 3'd5, 8'h66};
    csn_c = 1'b0;
    #5;
    for (int i = 21; i >= 0; i--) send_bit(1'b0, cw[i]);
    csn_c = 1'b1;
    #10;
    for (int c = 0; c < 4; c++) begin
      chk("R6 four-ch near ignored", w_a[c*8 +: 8], (c == 3) ? 8'h5A : 8'h80);
      chk("R6 four-ch far ignored", w_b[c*8 +: 8], (c == 1) ? 8'hA5 : 8'h80);
    end

    // R9: preset pulse after writes
    presetn = 1'b0;
    #10;
    for (int c = 0; c < 6; c++) model[c] = 8'h80;
    check_main("R1 preset after writes");
    chk("R1 sdo cleared", {7'd0, sdo_m}, 8'd0);
    presetn = 1'b1;
    #10;
    check_main("R9 codes after preset rise");
    for (int c = 0; c < 4; c++) chk("R9 chain after preset", w_a[c*8 +: 8], 8'h80);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule